// File: doc/BRIEF.md
# Dual-Strategy Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It holds a small table of entries selected by the low bits of the branch address. Each entry remembers the last two resolved outcomes of the branches that map to it, and a hysteresis state made of a direction and a flag that marks a prediction that has only just changed. A front end presents an index on the lookup port and gets a taken or not-taken answer in the same cycle. When the branch resolves, the back end reports the index and the real outcome on the update port, and the entry changes on the next clock edge.

A mode input picks which of two strategies drives the lookup answer. In the history strategy the prediction is not-taken only when both remembered outcomes were not-taken. In the hysteresis strategy a settled prediction changes only after two wrong guesses in a row. A prediction that has just changed goes back to its previous direction after a single wrong guess. Both strategies are kept up to date on every update, whatever the mode, so the mode can be switched at any time with no warm-up.

Top module: `bp_dual_predictor`

## Requirements
- R1: After reset every entry holds a not-taken history and the settled not-taken state, so the lookup returns 0 (not-taken) in both modes for every index.
- R2: With mode_sel=0 (history strategy) the lookup returns 0 exactly when the last two updates of that index both carried up_taken=0; otherwise it returns 1.
- R3: With mode_sel=1 (hysteresis strategy) a settled prediction does not change after one wrong outcome. It changes to the opposite direction, and becomes a fresh prediction, after the second consecutive wrong outcome.
- R4: In the hysteresis strategy, a wrong outcome on a fresh prediction restores the previous direction as a settled prediction.
- R5: In the hysteresis strategy, a correct outcome on a fresh prediction makes it settled, so two further consecutive wrong outcomes are then needed to change it.
- R6: In the hysteresis strategy, a single not-taken outcome, such as a loop exit, that follows a run of taken outcomes leaves the taken prediction unchanged.
- R7: An update changes only the entry selected by up_idx, and only when up_valid=1. With up_valid=0 no entry changes.
- R8: When the lookup and an update target the same index in the same cycle, the lookup returns the value from before that update. The new value is visible from the next cycle.
- R9: Both strategies are updated on every valid update regardless of mode_sel, and the lookup output follows mode_sel combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 1 | 0 = history strategy, 1 = hysteresis strategy |
| lk_idx | input | IDX_W | Lookup index (low branch-address bits) |
| lk_taken | output | 1 | Predicted direction, 1 = taken |
| up_valid | input | 1 | Apply an update this cycle |
| up_idx | input | IDX_W | Index of the resolved branch |
| up_taken | input | 1 | Resolved outcome, 1 = taken |

## Verification
The assertions assume that up_valid, up_idx, up_taken, lk_idx and mode_sel are known and settle before each rising edge. They also assume that up_valid is low while reset is held. The bench changes every input only at the falling edge, holds up_valid low from time zero until reset is released, and never leaves an input undriven. Because of that, the hold and transition properties only ever see clean, stable values.

// File: rtl/bp_pkg.sv
package bp_pkg;

  // Hysteresis state of one entry: predicted direction plus fresh-change flag.
  typedef struct packed {
    logic fresh;
    logic dir;
  } hyst_t;

  localparam hyst_t HYST_RESET = '{fresh: 1'b0, dir: 1'b0};

  // Shift the newest outcome into bit 0, the older one moves to bit 1.
  function automatic logic [1:0] hist_push(input logic [1:0] h, input logic t);
    return {h[0], t};
  endfunction

  // History strategy: not-taken only when both remembered outcomes were not-taken.
  function automatic logic hist_pred(input logic [1:0] h);
    return |h;
  endfunction

  // Hysteresis strategy next state; prev is the outcome of the update before this one.
  function automatic hyst_t hyst_next(input hyst_t s, input logic prev, input logic t);
    hyst_t n;
    n = s;
    if (t == s.dir) begin
      n.fresh = 1'b0;
    end else if (s.fresh) begin
      n.fresh = 1'b0;
      n.dir   = ~s.dir;
    end else if (prev != s.dir) begin
      n.fresh = 1'b1;
      n.dir   = t;
    end
    return n;
  endfunction

endpackage

// File: rtl/bp_entry.sv
module bp_entry
  import bp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic wr_taken,
  output logic pred_hist,
  output logic pred_hyst
);

  logic [1:0] hist_q;
  hyst_t      hyst_q;

  // Named events for the assertions
  logic ev_wrong;
  logic ev_second_wrong;
  logic ev_revert;
  assign ev_wrong        = wr_en && (wr_taken != hyst_q.dir);
  assign ev_second_wrong = ev_wrong && !hyst_q.fresh && (hist_q[0] != hyst_q.dir);
  assign ev_revert       = ev_wrong && hyst_q.fresh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= 2'b00;
      hyst_q <= HYST_RESET;
    end else if (wr_en) begin
      hist_q <= hist_push(hist_q, wr_taken);
      hyst_q <= hyst_next(hyst_q, hist_q[0], wr_taken);
    end
  end

  assign pred_hist = hist_pred(hist_q);
  assign pred_hyst = hyst_q.dir;

  // R3: one wrong outcome on a settled prediction keeps the direction
  a_r3_single_err_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_wrong && !ev_second_wrong && !hyst_q.fresh) |=> (pred_hyst == $past(pred_hyst)));

  // R3: a second consecutive wrong outcome flips to a fresh prediction
  a_r3_flip_on_second: assert property (@(posedge clk) disable iff (!rst_n)
    ev_second_wrong |=> (pred_hyst != $past(pred_hyst)) && hyst_q.fresh);

  // R4: a wrong outcome on a fresh prediction restores the earlier one, settled
  a_r4_revert: assert property (@(posedge clk) disable iff (!rst_n)
    ev_revert |=> (pred_hyst != $past(pred_hyst)) && !hyst_q.fresh);

  // R7: without a write nothing in the entry moves
  a_r7_no_write_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(pred_hist) && $stable(pred_hyst) && $stable(hyst_q.fresh));

endmodule

// File: rtl/bp_sel.sv
module bp_sel #(
  parameter int IDX_W = 4,
  localparam int N = 1 << IDX_W
) (
  input  logic [N-1:0]     hist_vec,
  input  logic [N-1:0]     hyst_vec,
  input  logic             mode_sel,
  input  logic [IDX_W-1:0] idx,
  output logic             taken
);

  logic a_bit;
  logic b_bit;
  assign a_bit = hist_vec[idx];
  assign b_bit = hyst_vec[idx];
  assign taken = mode_sel ? b_bit : a_bit;

endmodule

// File: rtl/bp_dual_predictor.sv
module bp_dual_predictor #(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_sel,
  input  logic [IDX_W-1:0] lk_idx,
  output logic             lk_taken,
  input  logic             up_valid,
  input  logic [IDX_W-1:0] up_idx,
  input  logic             up_taken
);

  localparam int N = 1 << IDX_W;

  logic [N-1:0] wr_vec;
  logic [N-1:0] hist_vec;
  logic [N-1:0] hyst_vec;

  for (genvar g = 0; g < N; g++) begin : g_ent
    assign wr_vec[g] = up_valid && (up_idx == IDX_W'(g));
    bp_entry u_ent (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_vec[g]),
      .wr_taken  (up_taken),
      .pred_hist (hist_vec[g]),
      .pred_hyst (hyst_vec[g])
    );
  end

  bp_sel #(.IDX_W(IDX_W)) u_sel (
    .hist_vec (hist_vec),
    .hyst_vec (hyst_vec),
    .mode_sel (mode_sel),
    .idx      (lk_idx),
    .taken    (lk_taken)
  );

  // R7: at most one entry written per cycle, none when idle
  a_r7_one_writer: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_vec) && (up_valid || (wr_vec == '0)));

  // R7: with no update the answer for a steady lookup stays steady
  a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!up_valid) && $stable(lk_idx) && $stable(mode_sel)) |-> $stable(lk_taken));

endmodule

// File: tb/tb_bp_dual_predictor.sv
module tb_bp_dual_predictor;

  localparam int IDX_W = 4;
  localparam int N = 1 << IDX_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_sel = 1'b0;
  logic [IDX_W-1:0] lk_idx = '0;
  logic lk_taken;
  logic up_valid = 1'b0;
  logic [IDX_W-1:0] up_idx = '0;
  logic up_taken = 1'b0;

  always #2.5 clk = ~clk;

  bp_dual_predictor #(.IDX_W(IDX_W)) dut (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .lk_idx(lk_idx),
    .lk_taken(lk_taken), .up_valid(up_valid), .up_idx(up_idx), .up_taken(up_taken)
  );

  typedef struct {
    logic  exp;
    string tag;
  } item_t;

  item_t sb_q[$];
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // Bench model: newest outcome, older outcome, hysteresis direction and fresh flag
  logic m_new [N];
  logic m_old [N];
  logic m_dir [N];
  logic m_frs [N];

  task automatic model_reset();
    for (int i = 0; i < N; i++) begin
      m_new[i] = 0; m_old[i] = 0; m_dir[i] = 0; m_frs[i] = 0;
    end
  endtask

  task automatic model_update(input int i, input logic t);
    logic was_new;
    was_new = m_new[i];
    if (t != m_dir[i]) begin
      if (m_frs[i]) begin
        m_dir[i] = t; m_frs[i] = 0;
      end else if (was_new == t) begin
        m_dir[i] = t; m_frs[i] = 1;
      end
    end else begin
      m_frs[i] = 0;
    end
    m_old[i] = was_new;
    m_new[i] = t;
  endtask

  // Driver: one cycle of stimulus plus the expected lookup result
  task automatic step(input logic md, input int li, input logic uv, input int ui,
                      input logic ut, input string tag);
    item_t it;
    @(negedge clk);
    mode_sel = md; lk_idx = IDX_W'(li);
    up_valid = uv; up_idx = IDX_W'(ui); up_taken = ut;
    it.exp = md ? m_dir[li] : (m_new[li] | m_old[li]);
    it.tag = tag;
    sb_q.push_back(it);
    if (uv) model_update(ui, ut);
  endtask

  task automatic upd(input int i, input logic t);
    step(1'b0, i, 1'b1, i, t, "R2");
  endtask

  // Monitor: compare away from the rising edge
  initial begin
    forever begin
      @(negedge clk);
      #1.5;
      if (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        checks++;
        if (lk_taken !== it.exp) begin
          failures++;
          $display("FAIL %s: lk_taken=%0b expected=%0b at %0t", it.tag, lk_taken, it.exp, $time);
        end
      end
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state in both modes
    for (int i = 0; i < N; i += 5) begin
      step(1'b0, i, 1'b0, 0, 1'b0, "R1");
      step(1'b1, i, 1'b0, 0, 1'b0, "R1");
    end

    // R3 / R4 / R2 on index 3
    upd(3, 1);
    step(1'b1, 3, 1'b0, 0, 1'b0, "R3");  // one wrong: still not-taken
    step(1'b0, 3, 1'b0, 0, 1'b0, "R2");  // history T,N -> taken
    upd(3, 1);
    step(1'b1, 3, 1'b0, 0, 1'b0, "R3");  // second wrong: taken
    upd(3, 0);
    step(1'b1, 3, 1'b0, 0, 1'b0, "R4");  // revert to not-taken
    step(1'b0, 3, 1'b0, 0, 1'b0, "R2");  // history T,N -> taken
    upd(3, 0);
    step(1'b0, 3, 1'b0, 0, 1'b0, "R2");  // history N,N -> not-taken

    // R5 on index 5: settle the fresh prediction, then it needs two errors
    upd(5, 1); upd(5, 1); upd(5, 1);
    upd(5, 0);
    step(1'b1, 5, 1'b0, 0, 1'b0, "R5");
    upd(5, 0);
    step(1'b1, 5, 1'b0, 0, 1'b0, "R5");

    // R6 loop exit on index 6
    upd(6, 1); upd(6, 1); upd(6, 1); upd(6, 1);
    upd(6, 0);
    step(1'b1, 6, 1'b0, 0, 1'b0, "R6");
    upd(6, 1);
    step(1'b1, 6, 1'b0, 0, 1'b0, "R6");

    // R7: invalid updates ignored, neighbours untouched
    step(1'b0, 7, 1'b0, 7, 1'b1, "R7");
    step(1'b0, 7, 1'b0, 7, 1'b1, "R7");
    step(1'b1, 7, 1'b0, 7, 1'b1, "R7");
    upd(8, 1); upd(8, 1);
    step(1'b0, 7, 1'b0, 0, 1'b0, "R7");
    step(1'b1, 9, 1'b0, 0, 1'b0, "R7");

    // R8: same-index lookup and update in one cycle
    step(1'b0, 10, 1'b1, 10, 1'b1, "R8");
    step(1'b0, 10, 1'b0, 0, 1'b0, "R8");
    step(1'b1, 10, 1'b1, 10, 1'b1, "R8");
    step(1'b1, 10, 1'b0, 0, 1'b0, "R8");

    // R9: hysteresis state learned while mode 0 is selected
    step(1'b0, 12, 1'b1, 12, 1'b1, "R9");
    step(1'b0, 12, 1'b1, 12, 1'b1, "R9");
    step(1'b1, 12, 1'b0, 0, 1'b0, "R9");
    step(1'b0, 12, 1'b1, 12, 1'b0, "R9");
    step(1'b1, 12, 1'b0, 0, 1'b0, "R9");

    // Mixed traffic in both modes
    for (int k = 0; k < 400; k++) begin
      step(1'($urandom_range(0, 1)), $urandom_range(0, N - 1), 1'($urandom_range(0, 1)),
           $urandom_range(0, 3), 1'($urandom_range(0, 1)), "R3");
    end

    step(1'b0, 0, 1'b0, 0, 1'b0, "R2");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule